// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a virtual address into a physical address by walking a two-level page table that sits in memory. A walk request brings the virtual address and the base address of the directory. The walker splits the virtual page number into a directory index (upper bits) and a table index (lower bits). It reads the directory entry, and if that entry is valid it uses the entry's frame number to locate the leaf entry and reads that too. The leaf frame number, joined with the untouched page offset, is the result.

The two reads depend on each other and go out one after the other through a single memory read port. That port has a valid/ready request channel and a response strobe. An invalid directory entry ends the walk at once, without a second read. An invalid leaf entry also ends the walk. The response carries a 2-bit code that says at which level a fault occurred. Only one walk is in flight: a new request is taken only after the previous response has been consumed.

With the default parameters, addresses are 14 bits virtual and 32 bits physical, pages are 64 bytes, and entries are 4 bytes. Each level has 16 entries.

Top module: `ptw_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and `mem_rd_valid` and `rsp_valid` are 0.
- R2: The first read of a walk goes to `req_base + dir_idx*4`, where `dir_idx` is `req_vaddr[13:10]`.
- R3: An entry is 32 bits: bit 31 is the valid flag and bits [25:0] are the frame number. Bits [30:26] have no effect on any address or result.
- R4: If the directory entry has bit 31 clear, the walk ends with `rsp_fault` = 2'b01 and `rsp_paddr` = 0, after exactly one read.
- R5: The second read goes to `(dir_frame << 6) + tbl_idx*4`, where `tbl_idx` is `req_vaddr[9:6]`.
- R6: When both entries are valid, `rsp_fault` = 2'b00 and `rsp_paddr` = `{leaf_frame[25:0], req_vaddr[5:0]}`, after exactly two reads.
- R7: If the leaf entry has bit 31 clear, the walk ends with `rsp_fault` = 2'b10 and `rsp_paddr` = 0, after exactly two reads.
- R8: While `mem_rd_ready` is low, `mem_rd_valid` stays high and `mem_rd_addr` stays unchanged.
- R9: `req_ready` is low from the accepted request until the response is consumed. While `rsp_ready` is low, `rsp_valid`, `rsp_paddr` and `rsp_fault` stay unchanged.
- R10: The code 2'b11 never appears on `rsp_fault`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Walk request present |
| req_ready | output | 1 | Walker idle, takes a request |
| req_vaddr | input | 14 | Virtual address to translate |
| req_base | input | 32 | Physical base of the directory |
| mem_rd_valid | output | 1 | Read request to memory |
| mem_rd_ready | input | 1 | Memory takes the read request |
| mem_rd_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Entry read from memory |
| rsp_valid | output | 1 | Translation result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_paddr | output | 32 | Physical address, 0 on a fault |
| rsp_fault | output | 2 | 00 none, 01 directory, 10 leaf |

## Verification
The properties assume that memory returns exactly one `mem_rsp_valid` pulse for each accepted read. They also assume the pulse comes no earlier than the cycle after the handshake and only while the walker is waiting for it. The bench's memory model does exactly that: it answers one cycle after the accepting edge and never raises the strobe otherwise. It can hold `mem_rd_ready` low for a chosen number of cycles, so the hold rule on the read request is exercised. The bench holds `rsp_ready` low for a few cycles on every walk before it consumes the result.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [2:0] {
    WS_IDLE    = 3'd0,
    WS_RD_DIR  = 3'd1,
    WS_WT_DIR  = 3'd2,
    WS_RD_LEAF = 3'd3,
    WS_WT_LEAF = 3'd4,
    WS_DONE    = 3'd5
  } walk_state_e;

  typedef enum logic [1:0] {
    FLT_NONE = 2'b00,
    FLT_DIR  = 2'b01,
    FLT_LEAF = 2'b10
  } walk_fault_e;

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int VA_W    = 14,
  parameter int OFF_W   = 6,
  parameter int DIR_W   = 4,
  parameter int PA_W    = 32,
  parameter int ENTRY_W = 32
) (
  input  logic [VA_W-OFF_W-1:0] vpn,
  input  logic [PA_W-1:0]       base,
  input  logic [PA_W-OFF_W-1:0] dir_frame,
  input  logic                  sel_leaf,
  output logic [PA_W-1:0]       rd_addr
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int TBL_W = VPN_W - DIR_W;
  localparam int ESH   = $clog2(ENTRY_W / 8);

  logic [DIR_W-1:0] dir_idx;
  logic [TBL_W-1:0] tbl_idx;
  logic [PA_W-1:0]  dir_entry_addr;
  logic [PA_W-1:0]  leaf_entry_addr;

  assign dir_idx = vpn[VPN_W-1 -: DIR_W];
  assign tbl_idx = vpn[TBL_W-1:0];

  // directory: base plus scaled upper index
  assign dir_entry_addr  = base + (PA_W'(dir_idx) << ESH);
  // leaf: frame moved into place, plus scaled lower index
  assign leaf_entry_addr = (PA_W'(dir_frame) << OFF_W) + (PA_W'(tbl_idx) << ESH);

  assign rd_addr = sel_leaf ? leaf_entry_addr : dir_entry_addr;
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
#(
  parameter int VA_W  = 14,
  parameter int OFF_W = 6,
  parameter int PA_W  = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [VA_W-1:0]       req_vaddr,
  input  logic [PA_W-1:0]       req_base,
  output logic                  mem_rd_valid,
  input  logic                  mem_rd_ready,
  input  logic                  mem_rsp_valid,
  input  logic                  ent_valid,
  input  logic [PA_W-OFF_W-1:0] ent_frame,
  output logic                  sel_leaf,
  output logic [VA_W-OFF_W-1:0] vpn_q,
  output logic [PA_W-1:0]       base_q,
  output logic [PA_W-OFF_W-1:0] dir_frame_q,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [PA_W-1:0]       rsp_paddr,
  output logic [1:0]            rsp_fault
);
  walk_state_e      state_q;
  logic [OFF_W-1:0] off_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= WS_IDLE;
      vpn_q       <= '0;
      off_q       <= '0;
      base_q      <= '0;
      dir_frame_q <= '0;
      rsp_paddr   <= '0;
      rsp_fault   <= FLT_NONE;
    end else begin
      case (state_q)
        WS_IDLE: if (req_valid) begin
          vpn_q   <= req_vaddr[VA_W-1:OFF_W];
          off_q   <= req_vaddr[OFF_W-1:0];
          base_q  <= req_base;
          state_q <= WS_RD_DIR;
        end
        WS_RD_DIR:  if (mem_rd_ready) state_q <= WS_WT_DIR;
        WS_WT_DIR: if (mem_rsp_valid) begin
          if (ent_valid) begin
            dir_frame_q <= ent_frame;
            state_q     <= WS_RD_LEAF;
          end else begin
            rsp_paddr <= '0;
            rsp_fault <= FLT_DIR;
            state_q   <= WS_DONE;
          end
        end
        WS_RD_LEAF: if (mem_rd_ready) state_q <= WS_WT_LEAF;
        WS_WT_LEAF: if (mem_rsp_valid) begin
          if (ent_valid) begin
            rsp_paddr <= {ent_frame, off_q};
            rsp_fault <= FLT_NONE;
          end else begin
            rsp_paddr <= '0;
            rsp_fault <= FLT_LEAF;
          end
          state_q <= WS_DONE;
        end
        WS_DONE: if (rsp_ready) state_q <= WS_IDLE;
        default: state_q <= WS_IDLE;
      endcase
    end
  end

  assign req_ready    = (state_q == WS_IDLE);
  assign mem_rd_valid = (state_q == WS_RD_DIR) || (state_q == WS_RD_LEAF);
  assign sel_leaf     = (state_q == WS_RD_LEAF);
  assign rsp_valid    = (state_q == WS_DONE);
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker #(
  parameter int VA_W    = 14,
  parameter int OFF_W   = 6,
  parameter int DIR_W   = 4,
  parameter int PA_W    = 32,
  parameter int ENTRY_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_vaddr,
  input  logic [PA_W-1:0]    req_base,
  output logic               mem_rd_valid,
  input  logic               mem_rd_ready,
  output logic [PA_W-1:0]    mem_rd_addr,
  input  logic               mem_rsp_valid,
  input  logic [ENTRY_W-1:0] mem_rsp_data,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [PA_W-1:0]    rsp_paddr,
  output logic [1:0]         rsp_fault
);
  localparam int VPN_W   = VA_W - OFF_W;
  localparam int FRAME_W = PA_W - OFF_W;

  logic               ent_valid;
  logic [FRAME_W-1:0] ent_frame;
  logic               sel_leaf;
  logic [VPN_W-1:0]   vpn_q;
  logic [PA_W-1:0]    base_q;
  logic [FRAME_W-1:0] dir_frame_q;
  logic               unused_ent_bits;

  assign ent_valid       = mem_rsp_data[ENTRY_W-1];
  assign ent_frame       = mem_rsp_data[FRAME_W-1:0];
  assign unused_ent_bits = &{1'b0, mem_rsp_data[ENTRY_W-2:FRAME_W]};

  ptw_ctrl #(.VA_W(VA_W), .OFF_W(OFF_W), .PA_W(PA_W)) ctrl_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_base(req_base),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
    .mem_rsp_valid(mem_rsp_valid),
    .ent_valid(ent_valid), .ent_frame(ent_frame),
    .sel_leaf(sel_leaf), .vpn_q(vpn_q), .base_q(base_q),
    .dir_frame_q(dir_frame_q),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
  );

  ptw_addr_gen #(
    .VA_W(VA_W), .OFF_W(OFF_W), .DIR_W(DIR_W), .PA_W(PA_W), .ENTRY_W(ENTRY_W)
  ) addr_i (
    .vpn(vpn_q), .base(base_q), .dir_frame(dir_frame_q),
    .sel_leaf(sel_leaf), .rd_addr(mem_rd_addr)
  );
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int VA_W    = 14,
  parameter int OFF_W   = 6,
  parameter int DIR_W   = 4,
  parameter int PA_W    = 32,
  parameter int ENTRY_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_ready,
  input logic [VA_W-1:0] req_vaddr,
  input logic [PA_W-1:0] req_base,
  input logic            mem_rd_valid,
  input logic            mem_rd_ready,
  input logic [PA_W-1:0] mem_rd_addr,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [PA_W-1:0] rsp_paddr,
  input logic [1:0]      rsp_fault
);
  localparam int ESH = $clog2(ENTRY_W / 8);

  logic [1:0]       rd_cnt;
  logic [OFF_W-1:0] off_q;
  logic [DIR_W-1:0] dir_q;
  logic [PA_W-1:0]  base_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_cnt <= '0; off_q <= '0; dir_q <= '0; base_q <= '0;
    end else if (req_valid && req_ready) begin
      rd_cnt <= '0;
      off_q  <= req_vaddr[OFF_W-1:0];
      dir_q  <= req_vaddr[VA_W-1 -: DIR_W];
      base_q <= req_base;
    end else if (mem_rd_valid && mem_rd_ready && rd_cnt != 2'd3) begin
      rd_cnt <= rd_cnt + 2'd1;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!rsp_valid && !mem_rd_valid)); // R9
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr))); // R8
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault))); // R9
  AST_DIR_ADDR: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_valid && rd_cnt == 2'd0) |-> (mem_rd_addr == base_q + (PA_W'(dir_q) << ESH))); // R2
  AST_DIR_FAULT_ONE_READ: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault == 2'b01) |-> (rd_cnt == 2'd1 && rsp_paddr == '0)); // R4
  AST_LEAF_TWO_READS: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault == 2'b10) |-> (rd_cnt == 2'd2 && rsp_paddr == '0)); // R7
  AST_OK_OFFSET: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault == 2'b00) |-> (rd_cnt == 2'd2 && rsp_paddr[OFF_W-1:0] == off_q)); // R6
  AST_NO_CODE3: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_fault != 2'b11)); // R10
endmodule

bind ptw_walker ptw_walker_chk #(
  .VA_W(VA_W), .OFF_W(OFF_W), .DIR_W(DIR_W), .PA_W(PA_W), .ENTRY_W(ENTRY_W)
) chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_vaddr(req_vaddr), .req_base(req_base),
  .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
);

// File: tb/ptw_walker_tb_top.sv
`timescale 1ns/1ps
module ptw_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_ready;
  logic [13:0] req_vaddr;
  logic [31:0] req_base;
  logic        mem_rd_valid, mem_rd_ready;
  logic [31:0] mem_rd_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        rsp_valid, rsp_ready;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_fault;

  int n_chk = 0, n_bad = 0;
  logic [31:0] tab_addr [8];
  logic [31:0] tab_data [8];
  int          tab_n;
  logic [31:0] rd_log [4];
  int          rd_n;
  int          stall;
  int          wait_cnt;
  bit          pend;
  logic [31:0] pend_addr, hold_addr;
  bit          hold_bad;
  bit          done_flag;

  always #2 clk = ~clk;

  ptw_walker dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_base(req_base),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] lookup(input logic [31:0] a);
    for (int i = 0; i < tab_n; i++) if (tab_addr[i] == a) return tab_data[i];
    return 32'h0;
  endfunction

  function automatic logic [31:0] dir_addr(input logic [31:0] base, input logic [13:0] va);
    return base + {26'd0, va[13:10], 2'b00};
  endfunction

  function automatic logic [31:0] leaf_addr(input logic [31:0] dent, input logic [13:0] va);
    return {dent[25:0], 6'd0} + {26'd0, va[9:6], 2'b00};
  endfunction

  // memory model: accepts after 'stall' cycles, answers one cycle later
  initial begin
    mem_rd_ready = 0; mem_rsp_valid = 0; mem_rsp_data = 0;
    wait_cnt = 0; pend = 0; hold_bad = 0; rd_n = 0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 0;
      mem_rd_ready  = 0;
      if (pend) begin
        mem_rsp_valid = 1;
        mem_rsp_data  = lookup(pend_addr);
        pend = 0;
      end else if (mem_rd_valid) begin
        if (wait_cnt > 0 && mem_rd_addr != hold_addr) hold_bad = 1;
        if (wait_cnt == 0) hold_addr = mem_rd_addr;
        if (wait_cnt < stall) wait_cnt++;
        else begin
          mem_rd_ready = 1;
          wait_cnt = 0;
          pend = 1;
          pend_addr = mem_rd_addr;
          if (rd_n < 4) rd_log[rd_n] = mem_rd_addr;
          rd_n++;
        end
      end else if (wait_cnt > 0) begin
        hold_bad = 1;
        wait_cnt = 0;
      end
    end
  end

  task automatic walk(input logic [13:0] va, input logic [31:0] base,
                      output logic [31:0] pa, output logic [1:0] flt);
    int guard;
    logic [31:0] pa0;
    logic [1:0]  f0;
    rd_n = 0;
    @(negedge clk);
    req_valid = 1; req_vaddr = va; req_base = base;
    @(negedge clk);
    req_valid = 0;
    check(req_ready == 0, "R9 busy after accept", {31'd0, req_ready}, 32'd0);
    guard = 0;
    while (!rsp_valid && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    pa0 = rsp_paddr; f0 = rsp_fault;
    repeat (2) @(negedge clk);
    check(rsp_valid && rsp_paddr == pa0 && rsp_fault == f0 && !req_ready,
          "R9 response held", rsp_paddr, pa0);
    pa = rsp_paddr; flt = rsp_fault;
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
    check(req_ready && !rsp_valid, "R9 idle after consume", {31'd0, req_ready}, 32'd1);
  endtask

  task automatic t_ok(input logic [13:0] va, input logic [31:0] base,
                      input logic [31:0] dent, input logic [31:0] lent, input string nm);
    logic [31:0] pa; logic [1:0] f;
    tab_n = 2;
    tab_addr[0] = dir_addr(base, va);   tab_data[0] = dent;
    tab_addr[1] = leaf_addr(dent, va);  tab_data[1] = lent;
    walk(va, base, pa, f);
    check(f == 2'b00, {"R6 fault code ", nm}, {30'd0, f}, 32'd0);
    check(pa == {lent[25:0], va[5:0]}, {"R6 paddr ", nm}, pa, {lent[25:0], va[5:0]});
    check(rd_n == 2, {"R6 read count ", nm}, rd_n, 2);
    check(rd_log[0] == dir_addr(base, va), {"R2 dir addr ", nm}, rd_log[0], dir_addr(base, va));
    check(rd_log[1] == leaf_addr(dent, va), {"R5 leaf addr ", nm}, rd_log[1], leaf_addr(dent, va));
  endtask

  task automatic t_dir_fault;
    logic [31:0] pa; logic [1:0] f;
    tab_n = 1;
    tab_addr[0] = dir_addr(32'h2000, 14'h3C15); tab_data[0] = 32'h7FFF_FFFF;
    walk(14'h3C15, 32'h2000, pa, f);
    check(f == 2'b01, "R4 fault code", {30'd0, f}, 32'd1);
    check(pa == 0, "R4 paddr zero", pa, 0);
    check(rd_n == 1, "R4 single read", rd_n, 1);
  endtask

  task automatic t_leaf_fault;
    logic [31:0] pa; logic [1:0] f;
    tab_n = 2;
    tab_addr[0] = dir_addr(32'h0400, 14'h1ABC); tab_data[0] = 32'h8000_0077;
    tab_addr[1] = leaf_addr(32'h8000_0077, 14'h1ABC); tab_data[1] = 32'h03FF_FFFF;
    walk(14'h1ABC, 32'h0400, pa, f);
    check(f == 2'b10, "R7 fault code", {30'd0, f}, 32'd2);
    check(pa == 0, "R7 paddr zero", pa, 0);
    check(rd_n == 2, "R7 two reads", rd_n, 2);
    check(rd_log[1] == leaf_addr(32'h8000_0077, 14'h1ABC), "R5 leaf addr on fault",
          rd_log[1], leaf_addr(32'h8000_0077, 14'h1ABC));
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    done_flag = 0; stall = 0;
    rst = 1; req_valid = 0; req_vaddr = 0; req_base = 0; rsp_ready = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(req_ready && !mem_rd_valid && !rsp_valid, "R1 reset state",
          {29'd0, req_ready, mem_rd_valid, rsp_valid}, 32'h4);
    t_ok(14'h24EA, 32'h0000_1000, 32'h8000_0040, 32'h8000_0123, "basic");
    t_dir_fault();
    t_leaf_fault();
    // R3: bits 30:26 set in both entries must not change anything
    t_ok(14'h0A55, 32'h0000_3000, 32'hFC00_0040, 32'hFC00_0005, "R3 ignored bits");
    // R8: read port stalls
    stall = 3;
    t_ok(14'h159F, 32'h0001_0000, 32'h8000_1234, 32'h8155_5555, "stalled");
    check(!hold_bad, "R8 request held while stalled", {31'd0, hold_bad}, 32'd0);
    stall = 0;
    // boundary: top indices, top offset, wrap-free maximum addresses
    t_ok(14'h3FFF, 32'hFFFF_FF00, 32'h83FF_FFFF, 32'h83FF_FFFF, "max indices");
    t_ok(14'h0000, 32'h0000_0000, 32'h8000_0000, 32'h8000_0000, "zero");
    check(!hold_bad, "R8 no drop of read request", {31'd0, hold_bad}, 32'd0);
    check(rsp_fault != 2'b11, "R10 code never 11", {30'd0, rsp_fault}, 32'd0);
    done_flag = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule